// File: doc/BRIEF.md
# Ethernet Transmit VLAN Tag Inserter

The block gathers an outgoing Ethernet frame, byte by byte, from one or more transmit segments into a local frame store. Software hands each segment over as a run of data beats. The frame begins with a beat that marks it as the first, and ends with a beat that marks it as the last. The beat carrying the last marker also carries the per-frame request to add an 802.1Q tag and the 16-bit tag control value for that frame.

Once the whole frame is held, the block decides whether to tag it. If it tags the frame, the 4 tag bytes go in after the two MAC addresses; this happens while the frame is read out, so nothing is moved inside the store. The frame then leaves on a byte stream with valid/ready handshaking and an end marker.

Three sticky status flags record what happened: a frame was sent, a frame was damaged or could not be handled as asked, and a segment read failed on the bus. Writing 1 to a flag's bit position clears that flag.

Top module: `vlan_tx_tagger`

## Requirements
- R1: After reset, `out_valid_o` is 0, `sts_o` is 0 and `in_ready_o` is 1.
- R2: When tagging is requested and the frame holds at least 14 bytes, the output is built as follows. Bytes 0 to 11 come out as received. They are followed by 0x81, 0x00, then the tag control value with its high byte first. The remaining input bytes follow from input offset 12 onward, so the output is 4 bytes longer than the input.
- R3: When tagging is not requested, the frame comes out byte for byte unchanged.
- R4: When the input bytes at offsets 12 and 13 are already 0x81 and 0x00, no tag is added even if one is requested, and no status flag other than sent is raised.
- R5: When tagging is requested for a frame shorter than 14 bytes, the frame comes out unchanged in content and length, and the lost flag (`sts_o[1]`) is set.
- R6: The frame store holds `BUF_BYTES` bytes, and input bytes beyond that count are discarded with the lost flag set. When adding a tag would push the length past `BUF_BYTES`, the lost flag is set and the last 4 input bytes are dropped. The tag is still added, so the output length equals the held input length.
- R7: The tag request and tag value are taken only from the beat marked last; the values on every earlier beat have no effect. A beat with `in_keep_i` low stands for a zero-length segment: it adds no byte and raises no status.
- R8: A beat with `in_err_i` set sets the bus-error flag (`sts_o[2]`). The frame it belongs to is discarded up to and including its last beat: nothing is output for it and the sent flag is not set. The following frame is handled normally.
- R9: The sent flag (`sts_o[0]`) is set each time the final byte of a frame is handed over. All flags stay set until a write on `clr_valid_i` with a 1 at their bit position in `clr_mask_i`. Bits written 0 are left unchanged.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` and `out_last_o` hold steady. `in_ready_o` stays low for as long as a frame is being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Segment beat valid |
| in_ready_o | output | 1 | Block can accept a segment beat |
| in_data_i | input | 8 | Segment data byte |
| in_keep_i | input | 1 | Beat carries a byte (low: zero-length segment) |
| in_first_i | input | 1 | First beat of a frame |
| in_last_i | input | 1 | Last beat of a frame |
| in_err_i | input | 1 | Bus read of this beat failed |
| in_tag_en_i | input | 1 | Tag request, taken on the last beat |
| in_tci_i | input | 16 | Tag control value, taken on the last beat |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream accepts the output byte |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final byte of the output frame |
| clr_valid_i | input | 1 | Status clear strobe |
| clr_mask_i | input | 3 | Write-1-to-clear mask for the status flags |
| sts_o | output | 3 | Status: bit 0 sent, bit 1 lost, bit 2 bus error |

## Verification
The hardest situation to reach from the ports is the tag that lands exactly at, or just past, the store's capacity. Reaching it takes a frame of 2044 or 2045 bytes, and the trimmed output must then be compared byte by byte against a model of the splice. The bench streams such long frames from a table and checks each against a byte model it computes itself. It stalls the output every third cycle so that the splice is also seen holding under back-pressure. A bus error in the middle of a frame is also injected, followed by a clean frame, to show that the abandoned frame leaves no trace in the next one.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_DROP,
    ST_DECIDE,
    ST_SEND
  } vtag_state_e;

  localparam int unsigned STS_SENT   = 0;
  localparam int unsigned STS_LOST   = 1;
  localparam int unsigned STS_BUSERR = 2;
  localparam int unsigned STS_W      = 3;

  localparam logic [15:0] TPID       = 16'h8100;
  localparam int unsigned MAC_BYTES  = 12;
  localparam int unsigned HDR_BYTES  = 14;
  localparam int unsigned TAG_BYTES  = 4;
endpackage

// File: rtl/vtag_frame_buf.sv
module vtag_frame_buf #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o,
  output logic [15:0]   ethtype_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o   = mem_q[raddr_i];
  // bytes sitting right after both MAC addresses
  assign ethtype_o = {mem_q[vtag_pkg::MAC_BYTES], mem_q[vtag_pkg::MAC_BYTES + 1]};
endmodule

// File: rtl/vtag_splice.sv
module vtag_splice #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] idx_i,
  input  logic [CW-1:0] total_i,
  input  logic          ins_i,
  input  logic [15:0]   tci_i,
  input  logic [7:0]    buf_byte_i,
  output logic [AW-1:0] raddr_o,
  output logic [7:0]    byte_o,
  output logic          last_o
);
  import vtag_pkg::*;

  localparam logic [CW-1:0] TAG_LO = CW'(MAC_BYTES);
  localparam logic [CW-1:0] TAG_HI = CW'(MAC_BYTES + TAG_BYTES);

  logic          in_tag;
  logic [1:0]    tag_pos;
  logic [CW-1:0] src_idx;
  logic [31:0]   tag_word;

  assign in_tag   = ins_i && (idx_i >= TAG_LO) && (idx_i < TAG_HI);
  assign tag_pos  = 2'(idx_i - TAG_LO);
  assign src_idx  = (ins_i && idx_i >= TAG_HI) ? idx_i - CW'(TAG_BYTES) : idx_i;
  assign raddr_o  = AW'(src_idx);
  assign tag_word = {TPID, tci_i};

  always_comb begin
    byte_o = buf_byte_i;
    if (in_tag) begin
      unique case (tag_pos)
        2'd0:    byte_o = tag_word[31:24];
        2'd1:    byte_o = tag_word[23:16];
        2'd2:    byte_o = tag_word[15:8];
        default: byte_o = tag_word[7:0];
      endcase
    end
  end

  assign last_o = (idx_i == total_i - CW'(1));
endmodule

// File: rtl/vtag_status.sv
module vtag_status #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[b]) q <= 1'b1;   // set beats clear
      else if (clr_i[b]) q <= 1'b0;
    end
    assign sts_o[b] = q;
  end
endmodule

// File: rtl/vlan_tx_tagger.sv
module vlan_tx_tagger #(
  parameter int unsigned BUF_BYTES = 2048
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [7:0]  in_data_i,
  input  logic        in_keep_i,
  input  logic        in_first_i,
  input  logic        in_last_i,
  input  logic        in_err_i,
  input  logic        in_tag_en_i,
  input  logic [15:0] in_tci_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [7:0]  out_data_o,
  output logic        out_last_o,
  input  logic        clr_valid_i,
  input  logic [2:0]  clr_mask_i,
  output logic [2:0]  sts_o
);
  import vtag_pkg::*;

  localparam int unsigned AW = $clog2(BUF_BYTES);
  localparam int unsigned CW = $clog2(BUF_BYTES + 1);
  localparam logic [CW-1:0] CAP   = CW'(BUF_BYTES);
  localparam logic [CW:0]   CAP_X = (CW+1)'(BUF_BYTES);

  vtag_state_e   state_q;
  logic [CW-1:0] wcnt_q, idx_q, total_q;
  logic          ins_q, tag_en_q;
  logic [15:0]   tci_q;

  logic          beat_acc, room, we;
  logic [CW-1:0] base;
  logic [AW-1:0] raddr;
  logic [7:0]    rdata;
  logic [15:0]   ethtype;
  logic          pre_tagged, want_tag, too_short, grows_over;
  logic [STS_W-1:0] sts_set, sts_clr;

  assign in_ready_o  = (state_q == ST_COLLECT) || (state_q == ST_DROP);
  assign out_valid_o = (state_q == ST_SEND);
  assign beat_acc    = in_valid_i && in_ready_o;
  assign base        = in_first_i ? '0 : wcnt_q;
  assign room        = base < CAP;
  assign we          = (state_q == ST_COLLECT) && beat_acc && !in_err_i && in_keep_i && room;

  vtag_frame_buf #(.DEPTH(BUF_BYTES)) i_buf (
    .clk_i     (clk_i),
    .we_i      (we),
    .waddr_i   (AW'(base)),
    .wdata_i   (in_data_i),
    .raddr_i   (raddr),
    .rdata_o   (rdata),
    .ethtype_o (ethtype)
  );

  vtag_splice #(.DEPTH(BUF_BYTES)) i_splice (
    .idx_i      (idx_q),
    .total_i    (total_q),
    .ins_i      (ins_q),
    .tci_i      (tci_q),
    .buf_byte_i (rdata),
    .raddr_o    (raddr),
    .byte_o     (out_data_o),
    .last_o     (out_last_o)
  );

  // decision terms, valid in ST_DECIDE
  assign pre_tagged = (wcnt_q >= CW'(HDR_BYTES)) && (ethtype == TPID);
  assign want_tag   = tag_en_q && !pre_tagged;
  assign too_short  = wcnt_q < CW'(HDR_BYTES);
  assign grows_over = ({1'b0, wcnt_q} + (CW+1)'(TAG_BYTES)) > CAP_X;

  always_comb begin
    sts_set = '0;
    sts_set[STS_BUSERR] = (state_q == ST_COLLECT) && beat_acc && in_err_i;
    sts_set[STS_LOST]   = ((state_q == ST_COLLECT) && beat_acc && !in_err_i && in_keep_i && !room)
                       || ((state_q == ST_DECIDE) && (wcnt_q != '0) && want_tag
                           && (too_short || grows_over));
    sts_set[STS_SENT]   = (state_q == ST_SEND) && out_ready_i && out_last_o;
  end

  assign sts_clr = clr_valid_i ? clr_mask_i : '0;

  vtag_status #(.W(STS_W)) i_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sts_set),
    .clr_i  (sts_clr),
    .sts_o  (sts_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_COLLECT;
      wcnt_q   <= '0;
      idx_q    <= '0;
      total_q  <= '0;
      ins_q    <= 1'b0;
      tag_en_q <= 1'b0;
      tci_q    <= '0;
    end else begin
      unique case (state_q)
        ST_COLLECT: begin
          if (beat_acc) begin
            if (in_err_i) begin
              wcnt_q  <= '0;
              state_q <= in_last_i ? ST_COLLECT : ST_DROP;
            end else begin
              if (in_keep_i && room) wcnt_q <= base + CW'(1);
              else                   wcnt_q <= base;
              if (in_last_i) begin
                tag_en_q <= in_tag_en_i;
                tci_q    <= in_tci_i;
                state_q  <= ST_DECIDE;
              end
            end
          end
        end
        ST_DROP: begin
          if (beat_acc && in_last_i) state_q <= ST_COLLECT;
        end
        ST_DECIDE: begin
          idx_q <= '0;
          if (wcnt_q == '0) begin
            state_q <= ST_COLLECT;
          end else begin
            state_q <= ST_SEND;
            if (want_tag && !too_short) begin
              ins_q   <= 1'b1;
              // trimmed frame keeps its length once tagged
              total_q <= grows_over ? wcnt_q : wcnt_q + CW'(TAG_BYTES);
            end else begin
              ins_q   <= 1'b0;
              total_q <= wcnt_q;
            end
          end
        end
        ST_SEND: begin
          if (out_ready_i) begin
            if (out_last_o) begin
              state_q <= ST_COLLECT;
              wcnt_q  <= '0;
            end else begin
              idx_q <= idx_q + CW'(1);
            end
          end
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/vtag_checker.sv
module vtag_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic [7:0]  in_data_i,
  input logic        in_keep_i,
  input logic        in_first_i,
  input logic        in_last_i,
  input logic        in_err_i,
  input logic        in_tag_en_i,
  input logic [15:0] in_tci_i,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [7:0]  out_data_o,
  input logic        out_last_o,
  input logic        clr_valid_i,
  input logic [2:0]  clr_mask_i,
  input logic [2:0]  sts_o
);
  a_r10_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));

  a_r10_no_intake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  a_r9_sent_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> sts_o[0]);

  a_r8_bus_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && in_err_i |=> sts_o[2]);

  for (genvar b = 0; b < 3; b++) begin : g_sticky
    a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sts_o[b] && !(clr_valid_i && clr_mask_i[b]) |=> sts_o[b]);
  end
endmodule

bind vlan_tx_tagger vtag_checker i_vtag_checker (.*);

// File: tb/test_vlan_tx_tagger.sv
module test_vlan_tx_tagger;
  localparam int BUF = 2048;
  localparam int NV  = 12;
  // {len[11:0], tag_en, pre_tagged, split, exp_len[11:0], exp_lost, pad[3:0]}
  localparam logic [31:0] VEC [NV] = '{
    {12'd60,   1'b1, 1'b0, 1'b0, 12'd60 + 12'd4, 1'b0, 4'h0},
    {12'd60,   1'b0, 1'b0, 1'b1, 12'd60,   1'b0, 4'h0},
    {12'd40,   1'b1, 1'b1, 1'b0, 12'd40,   1'b0, 4'h0},
    {12'd10,   1'b1, 1'b0, 1'b0, 12'd10,   1'b1, 4'h0},
    {12'd13,   1'b1, 1'b0, 1'b1, 12'd13,   1'b1, 4'h0},
    {12'd14,   1'b1, 1'b0, 1'b0, 12'd18,   1'b0, 4'h0},
    {12'd100,  1'b1, 1'b0, 1'b1, 12'd104,  1'b0, 4'h0},
    {12'd2044, 1'b1, 1'b0, 1'b0, 12'd2048, 1'b0, 4'h0},
    {12'd2045, 1'b1, 1'b0, 1'b0, 12'd2045, 1'b1, 4'h0},
    {12'd2048, 1'b1, 1'b0, 1'b1, 12'd2048, 1'b1, 4'h0},
    {12'd2050, 1'b0, 1'b0, 1'b0, 12'd2048, 1'b1, 4'h0},
    {12'd12,   1'b0, 1'b0, 1'b0, 12'd12,   1'b0, 4'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_keep = 0, in_first = 0, in_last = 0, in_err = 0, in_tag_en = 0;
  logic [7:0] in_data = 0;
  logic [15:0] in_tci = 0;
  logic out_ready = 0, clr_valid = 0;
  logic [2:0] clr_mask = 0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;
  logic [2:0] sts;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] ibuf [0:2099];
  logic [7:0] obuf [0:2099];

  always #4 clk = ~clk;

  vlan_tx_tagger #(.BUF_BYTES(BUF)) i_vlan_tx_tagger (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data), .in_keep_i(in_keep),
    .in_first_i(in_first), .in_last_i(in_last), .in_err_i(in_err),
    .in_tag_en_i(in_tag_en), .in_tci_i(in_tci),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data), .out_last_o(out_last),
    .clr_valid_i(clr_valid), .clr_mask_i(clr_mask), .sts_o(sts)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_beat(input logic [7:0] d, input bit keep, input bit first, input bit last,
                          input bit err, input bit ten, input logic [15:0] tci);
    bit r;
    in_valid = 1; in_data = d; in_keep = keep; in_first = first; in_last = last;
    in_err = err; in_tag_en = ten; in_tci = tci;
    do begin
      r = in_ready;
      @(negedge clk);
    end while (!r);
  endtask

  // feeds ibuf[0:len-1]; non-last beats carry the opposite tag request (R7)
  task automatic send_frame(input int len, input bit en, input logic [15:0] tci,
                            input bit split, input int err_at);
    for (int i = 0; i < len; i++) begin
      if (split && i == len / 2)
        put_beat(8'hEE, 1'b0, 1'b0, 1'b0, 1'b0, !en, ~tci);
      put_beat(ibuf[i], 1'b1, i == 0, i == len - 1, i == err_at,
               (i == len - 1) ? en : !en, (i == len - 1) ? tci : ~tci);
    end
    in_valid = 0; in_last = 0; in_first = 0; in_err = 0;
  endtask

  task automatic recv_frame(output int n);
    bit fin = 0, held = 0;
    logic [7:0] hd;
    logic hl;
    int cyc = 0;
    n = 0;
    while (!fin && cyc < 6000) begin
      out_ready = (cyc % 3) != 2;
      if (held && out_valid)
        chk(out_data == hd && out_last == hl, "R10 hold under stall", int'(out_data), int'(hd));
      held = 0;
      if (out_valid && out_ready) begin
        obuf[n] = out_data;
        n++;
        if (out_last) fin = 1;
      end else if (out_valid) begin
        held = 1; hd = out_data; hl = out_last;
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 0;
  endtask

  task automatic clear(input logic [2:0] m);
    clr_valid = 1; clr_mask = m;
    @(negedge clk);
    clr_valid = 0; clr_mask = 0;
  endtask

  function automatic string req_of(input int v);
    case (v)
      0, 5:       return "R2";
      1, 11:      return "R3";
      2:          return "R4";
      3, 4:       return "R5";
      6:          return "R7";
      default:    return "R6";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, mism, first_bad;
    logic [7:0] eb;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    chk(sts == 0, "R1 sts", int'(sts), 0);
    chk(in_ready == 1, "R1 in_ready", int'(in_ready), 1);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int len, explen, held_len;
      bit en, pre, split, lost, ins;
      logic [15:0] tci;
      len = int'(VEC[v][31:20]); en = VEC[v][19]; pre = VEC[v][18]; split = VEC[v][17];
      explen = int'(VEC[v][16:5]); lost = VEC[v][4];
      tci = {4'hA, v[3:0], 8'h5C};
      for (int i = 0; i < len; i++) ibuf[i] = 8'((i * 3 + v * 17) & 255);
      if (pre) begin ibuf[12] = 8'h81; ibuf[13] = 8'h00; end
      held_len = (len > BUF) ? BUF : len;
      ins = en && !pre && held_len >= 14;
      send_frame(len, en, tci, split, -1);
      recv_frame(n);
      chk(n == explen, {req_of(v), " length"}, n, explen);
      mism = 0; first_bad = -1; eb = 0;
      for (int k = 0; k < explen && k < n; k++) begin
        logic [7:0] e;
        if (!ins)        e = ibuf[k];
        else if (k < 12) e = ibuf[k];
        else if (k == 12) e = 8'h81;
        else if (k == 13) e = 8'h00;
        else if (k == 14) e = tci[15:8];
        else if (k == 15) e = tci[7:0];
        else             e = ibuf[k - 4];
        if (obuf[k] !== e) begin
          mism++;
          if (first_bad < 0) begin first_bad = k; eb = e; end
        end
      end
      chk(mism == 0, {req_of(v), " bytes"}, first_bad < 0 ? 0 : int'(obuf[first_bad]), int'(eb));
      // R9 sent flag plus lost per R5/R6
      chk(sts == {1'b0, lost, 1'b1}, {req_of(v), " R9 status"}, int'(sts), int'({1'b0, lost, 1'b1}));
      clear(3'b010);
      chk(sts == 3'b001, "R9 partial clear", int'(sts), 1);
      clear(3'b001);
      chk(sts == 3'b000, "R9 full clear", int'(sts), 0);
    end

    // R8 bus error mid-frame, then a clean frame
    for (int i = 0; i < 20; i++) ibuf[i] = 8'(200 + i);
    send_frame(20, 1'b1, 16'h1234, 1'b0, 5);
    out_ready = 1;
    begin
      bit seen = 0;
      repeat (12) begin
        if (out_valid) seen = 1;
        @(negedge clk);
      end
      chk(!seen, "R8 no output", int'(seen), 0);
    end
    out_ready = 0;
    chk(sts == 3'b100, "R8 status", int'(sts), 4);
    clear(3'b111);
    for (int i = 0; i < 20; i++) ibuf[i] = 8'(50 + i);
    send_frame(20, 1'b1, 16'hBEEF, 1'b0, -1);
    recv_frame(n);
    chk(n == 24, "R8 next frame length", n, 24);
    chk(obuf[0] == 8'd50 && obuf[14] == 8'hBE && obuf[15] == 8'hEF && obuf[23] == 8'd69,
        "R8 next frame bytes", int'(obuf[23]), 69);
    chk(sts == 3'b001, "R8 next frame status", int'(sts), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule